// File: doc/BRIEF.md
# Cache Flush Request Sequencer

This block turns an external, active-low flush request pin into a complete clean-and-invalidate pass over two small caches, one for data and one for instructions. The pin may change at any time, so it first passes through a synchronizer. A falling edge on the synchronized level is caught in a pending latch, which means a low pulse only one clock long is not lost. The pending request then waits for the core to report an instruction boundary. It also waits while a higher-priority external event is pending. Sampling is suspended while the clock-stop state, the core-init request or the debug probe-ready signal is active, and any edge seen during those times is discarded.

Once the request is accepted, the sequencer raises `busy` and scans the data cache with an index counter. It stops at every modified line and raises a writeback request for that index, holding it until the grant arrives. The line is invalidated only after the grant. Clean and empty lines are invalidated in one cycle each. It then invalidates every line of the instruction cache. Only after both caches are empty does it drive a one-cycle flush-acknowledge bus cycle, and `busy` drops in the following cycle. A falling edge that arrives during a pass is latched again and starts a second pass after the acknowledge.

When the pin is still low as reset is released, the block raises a float-test request and does not start a flush. Each cache is modelled as a register file of per-line states. A fill port and a lookup port give access to these states.

Top module: `cflush_sequencer`

## Requirements
- R1: A falling edge on `flush_n`, including a low pulse one clock long, is latched. With `ibound` high and `hi_pri_pend` low, `busy` is high after the 4th rising clock edge that follows the pin change (two synchronizer stages, the edge/latch register, then the state register).
- R2: A latched request starts only in a cycle where `ibound` is 1 and `hi_pri_pend` is 0. Until then it stays pending. Once `hi_pri_pend` drops with `ibound` high, `busy` is high after the next rising edge.
- R3: For each data line in the modified state, `wb_req` rises with `wb_idx` equal to the line index. It stays high with a stable index until `wb_gnt` is 1 at a rising edge. The line stays valid while the request waits. Writebacks are issued in ascending index order.
- R4: After a pass, every line of both caches reads as invalid on the lookup port.
- R5: `fack` is a single-cycle pulse, issued once per pass after all writebacks and invalidations. It comes 2*LINES + M*(1+W) cycles after `busy` rises, where M is the number of modified data lines and W is the number of cycles that each grant is withheld.
- R6: Edges on `flush_n` while `stop_clk`, `init_req` or `probe_rdy` is 1 are ignored. A level still low when the gating ends does not start a flush.
- R7: If the synchronized `flush_n` is 0 in the first cycle after reset is released, `float_test` goes to 1 and stays there until the next reset, and no flush starts. Otherwise `float_test` is 0.
- R8: `busy` is high from the cycle after acceptance through the `fack` cycle, and low in the cycle after `fack`.
- R9: A falling edge during a pass re-arms the latch. A second full pass then starts right after the acknowledge, with its own `fack`.
- R10: With `fill_en` = 1 at a rising edge, `fill_sel` = 0 writes data line `fill_idx` as modified (`fill_mod` = 1) or clean (`fill_mod` = 0), and `fill_sel` = 1 writes instruction line `fill_idx` as clean whatever `fill_mod` is. When idle, `rd_sel`/`rd_idx` return `rd_valid`/`rd_mod` of that line combinationally. All lines are invalid after reset.
- R11: Clean or empty data lines raise no writeback request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_n | input | 1 | Asynchronous active-low flush request pin |
| stop_clk | input | 1 | Clock-stop state active; suspends sampling |
| init_req | input | 1 | Core init request; suspends sampling |
| probe_rdy | input | 1 | Debug probe-ready; suspends sampling |
| ibound | input | 1 | Core is at an instruction boundary |
| hi_pri_pend | input | 1 | A higher-priority external event is pending |
| wb_gnt | input | 1 | Writeback grant |
| fill_en | input | 1 | Write a line state |
| fill_sel | input | 1 | 0 selects data cache, 1 selects instruction cache |
| fill_idx | input | IDX_W | Line index for fill |
| fill_mod | input | 1 | Fill data line as modified |
| rd_sel | input | 1 | 0 selects data cache, 1 selects instruction cache for lookup |
| rd_idx | input | IDX_W | Line index for lookup |
| wb_req | output | 1 | Writeback request for a modified data line |
| wb_idx | output | IDX_W | Index of the line to write back |
| fack | output | 1 | Flush-acknowledge bus cycle, one clock |
| busy | output | 1 | Flush in progress; core stalls cache accesses |
| float_test | output | 1 | Float-test request captured at reset release |
| rd_valid | output | 1 | Looked-up line is valid |
| rd_mod | output | 1 | Looked-up line is modified |

## Verification
Every check counts falling clock edges from the moment the bench drives the pin at a falling edge. `busy` is due at count 4, `fack` at 4 + 2*LINES + M*(1+W), and the drop of `busy` one count later. The bench samples at exactly those counts, so a pulse that comes early, comes late or lasts two cycles is reported. The grant responder withholds `wb_gnt` for a set number of cycles and logs `wb_idx` at each grant, which lets the index order and the stretched timing be compared with values computed from the fill pattern. Gating, priority and float-test cases are judged by `busy` and `float_test` staying at their expected levels over windows longer than the 4-cycle acceptance latency.

// File: rtl/cflush_pkg.sv
package cflush_pkg;

    localparam int DEF_LINES = 8;
    localparam int DEF_SYNC  = 2;

    typedef enum logic [1:0] {
        LS_INV   = 2'd0,
        LS_CLEAN = 2'd1,
        LS_MOD   = 2'd2
    } line_st_t;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_DSCAN,
        WK_DWB,
        WK_ISCAN,
        WK_ACK
    } walk_st_t;

    typedef struct packed {
        logic valid;
        logic dirty;
    } line_view_t;

    function automatic line_view_t view_of(line_st_t s);
        line_view_t v;
        v.valid = (s != LS_INV);
        v.dirty = (s == LS_MOD);
        return v;
    endfunction

    function automatic line_st_t fill_state(logic dirty);
        return dirty ? LS_MOD : LS_CLEAN;
    endfunction

endpackage

// File: rtl/cflush_edge_latch.sv
module cflush_edge_latch #(
    parameter int SYNC_STAGES = cflush_pkg::DEF_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic sample_en,
    input  logic accept,
    output logic pend,
    output logic float_req
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    logic                   prev_q;
    logic                   rst_seen_q;
    logic                   fall;

    // synchronizer chain, no reset so it keeps tracking the pin during reset
    always_ff @(posedge clk) begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end

    assign pin_s = sync_q[SYNC_STAGES-1];
    assign fall  = sample_en & prev_q & ~pin_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q     <= pin_s;
            pend       <= 1'b0;
            float_req  <= 1'b0;
            rst_seen_q <= 1'b1;
        end else begin
            prev_q     <= pin_s;
            rst_seen_q <= 1'b0;
            if (rst_seen_q) begin
                float_req <= ~pin_s;
            end
            if (fall) begin
                pend <= 1'b1;
            end else if (accept) begin
                pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cflush_tagstore.sv
module cflush_tagstore
    import cflush_pkg::*;
#(
    parameter int LINES   = DEF_LINES,
    parameter bit HAS_MOD = 1'b1,
    localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_mod,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output line_st_t         rd_st,
    output logic [LINES-1:0] vld_vec
);
    line_st_t lines_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                lines_q[i] <= LS_INV;
            end
        end else if (inv_en) begin
            lines_q[inv_idx] <= LS_INV;
        end else if (fill_en) begin
            lines_q[fill_idx] <= fill_state(HAS_MOD & fill_mod);
        end
    end

    assign rd_st = lines_q[rd_idx];

    for (genvar g = 0; g < LINES; g++) begin : g_vld
        assign vld_vec[g] = (lines_q[g] != LS_INV);
    end

endmodule

// File: rtl/cflush_walker.sv
module cflush_walker
    import cflush_pkg::*;
#(
    parameter int LINES  = DEF_LINES,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  line_st_t         d_st,
    input  logic             wb_gnt,
    output logic             accept,
    output logic             busy,
    output logic             fack,
    output logic             wb_req,
    output logic [IDX_W-1:0] idx,
    output logic             d_inv,
    output logic             i_inv
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

    walk_st_t         st_q;
    logic [IDX_W-1:0] idx_q;
    logic             at_last;
    logic             d_done;

    assign at_last = (idx_q == LAST);
    assign accept  = (st_q == WK_IDLE) && go;
    assign busy    = (st_q != WK_IDLE);
    assign fack    = (st_q == WK_ACK);
    assign wb_req  = (st_q == WK_DWB);
    assign idx     = idx_q;
    // a data line is finished when clean/empty during scan, or granted
    assign d_done  = ((st_q == WK_DSCAN) && (d_st != LS_MOD)) ||
                     ((st_q == WK_DWB) && wb_gnt);
    assign d_inv   = d_done;
    assign i_inv   = (st_q == WK_ISCAN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= WK_IDLE;
            idx_q <= '0;
        end else begin
            case (st_q)
                WK_IDLE: begin
                    if (go) begin
                        st_q  <= WK_DSCAN;
                        idx_q <= '0;
                    end
                end
                WK_DSCAN, WK_DWB: begin
                    if ((st_q == WK_DSCAN) && (d_st == LS_MOD)) begin
                        st_q <= WK_DWB;
                    end else if (d_done) begin
                        if (at_last) begin
                            st_q  <= WK_ISCAN;
                            idx_q <= '0;
                        end else begin
                            st_q  <= WK_DSCAN;
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                WK_ISCAN: begin
                    if (at_last) begin
                        st_q <= WK_ACK;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                WK_ACK: begin
                    st_q <= WK_IDLE;
                end
                default: begin
                    st_q <= WK_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/cflush_sequencer.sv
module cflush_sequencer
    import cflush_pkg::*;
#(
    parameter int LINES       = DEF_LINES,
    parameter int SYNC_STAGES = DEF_SYNC,
    localparam int IDX_W      = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_n,
    input  logic             stop_clk,
    input  logic             init_req,
    input  logic             probe_rdy,
    input  logic             ibound,
    input  logic             hi_pri_pend,
    input  logic             wb_gnt,
    input  logic             fill_en,
    input  logic             fill_sel,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_mod,
    input  logic             rd_sel,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_idx,
    output logic             fack,
    output logic             busy,
    output logic             float_test,
    output logic             rd_valid,
    output logic             rd_mod
);
    logic             sample_en;
    logic             pend;
    logic             go;
    logic             accept;
    logic [IDX_W-1:0] walk_idx;
    logic             d_inv;
    logic             i_inv;
    logic [IDX_W-1:0] d_rd_idx;
    line_st_t         d_st;
    line_st_t         i_st;
    logic [LINES-1:0] d_vld;
    logic [LINES-1:0] i_vld;
    line_view_t       view;

    assign sample_en = ~(stop_clk | init_req | probe_rdy);
    assign go        = pend & ibound & ~hi_pri_pend;
    assign d_rd_idx  = busy ? walk_idx : rd_idx;
    assign wb_idx    = walk_idx;

    cflush_edge_latch #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_latch (
        .clk      (clk),
        .rst      (rst),
        .pin_n    (flush_n),
        .sample_en(sample_en),
        .accept   (accept),
        .pend     (pend),
        .float_req(float_test)
    );

    cflush_walker #(
        .LINES(LINES)
    ) u_walk (
        .clk   (clk),
        .rst   (rst),
        .go    (go),
        .d_st  (d_st),
        .wb_gnt(wb_gnt),
        .accept(accept),
        .busy  (busy),
        .fack  (fack),
        .wb_req(wb_req),
        .idx   (walk_idx),
        .d_inv (d_inv),
        .i_inv (i_inv)
    );

    cflush_tagstore #(
        .LINES  (LINES),
        .HAS_MOD(1'b1)
    ) u_dstore (
        .clk     (clk),
        .rst     (rst),
        .fill_en (fill_en & ~fill_sel),
        .fill_idx(fill_idx),
        .fill_mod(fill_mod),
        .inv_en  (d_inv),
        .inv_idx (walk_idx),
        .rd_idx  (d_rd_idx),
        .rd_st   (d_st),
        .vld_vec (d_vld)
    );

    cflush_tagstore #(
        .LINES  (LINES),
        .HAS_MOD(1'b0)
    ) u_istore (
        .clk     (clk),
        .rst     (rst),
        .fill_en (fill_en & fill_sel),
        .fill_idx(fill_idx),
        .fill_mod(fill_mod),
        .inv_en  (i_inv),
        .inv_idx (walk_idx),
        .rd_idx  (rd_idx),
        .rd_st   (i_st),
        .vld_vec (i_vld)
    );

    assign view     = view_of(rd_sel ? i_st : d_st);
    assign rd_valid = view.valid;
    assign rd_mod   = view.dirty;

endmodule

// File: rtl/cflush_chk.sv
module cflush_chk #(
    parameter int LINES  = 8,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             ibound,
    input logic             hi_pri_pend,
    input logic             wb_req,
    input logic             wb_gnt,
    input logic [IDX_W-1:0] wb_idx,
    input logic             fack,
    input logic             busy,
    input logic             float_test,
    input logic [LINES-1:0] d_vld,
    input logic [LINES-1:0] i_vld
);
    // R2: a pass begins only at a boundary with no higher-priority event
    a_r2_start_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(ibound) && !$past(hi_pri_pend)));

    // R3: request held with a stable index until granted
    a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
        (wb_req && !wb_gnt) |=> (wb_req && $stable(wb_idx)));

    // R3: the line stays valid while its writeback is outstanding
    a_r3_line_kept: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> d_vld[wb_idx]);

    // R5: acknowledge only once both caches are empty
    a_r5_ack_clean: assert property (@(posedge clk) disable iff (rst)
        fack |-> ((d_vld == '0) && (i_vld == '0)));

    // R5: acknowledge is a single-cycle pulse
    a_r5_ack_single: assert property (@(posedge clk) disable iff (rst)
        fack |=> !fack);

    // R8: busy covers the acknowledge cycle and ends right after it
    a_r8_busy_ack: assert property (@(posedge clk) disable iff (rst)
        fack |-> busy);
    a_r8_busy_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(fack));

    // R7: float-test request only changes around reset release
    a_r7_float_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(float_test) |-> $past(rst, 2));

endmodule

bind cflush_sequencer cflush_chk #(
    .LINES(LINES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ibound     (ibound),
    .hi_pri_pend(hi_pri_pend),
    .wb_req     (wb_req),
    .wb_gnt     (wb_gnt),
    .wb_idx     (wb_idx),
    .fack       (fack),
    .busy       (busy),
    .float_test (float_test),
    .d_vld      (d_vld),
    .i_vld      (i_vld)
);

// File: tb/sim_cflush_sequencer.sv
`timescale 1ns/1ps
module sim_cflush_sequencer;
    localparam int LINES = 8;
    localparam int IW    = $clog2(LINES);
    localparam int NVEC  = 6;
    localparam logic [LINES-1:0] V_MASK [NVEC] = '{8'h00, 8'hFF, 8'h81, 8'h5A, 8'h01, 8'h80};
    localparam int V_DLY [NVEC] = '{0, 0, 2, 1, 3, 0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush_n = 1'b1, stop_clk = 1'b0, init_req = 1'b0, probe_rdy = 1'b0;
    logic ibound = 1'b1, hi_pri_pend = 1'b0, wb_gnt = 1'b0;
    logic fill_en = 1'b0, fill_sel = 1'b0, fill_mod = 1'b0, rd_sel = 1'b0;
    logic [IW-1:0] fill_idx = '0, rd_idx = '0;
    logic wb_req, fack, busy, float_test, rd_valid, rd_mod;
    logic [IW-1:0] wb_idx;

    int errs = 0, nchk = 0;
    int gnt_delay = 0, gcnt = 0, nlog = 0;
    int glog [64];

    always #2 clk = ~clk;

    cflush_sequencer #(.LINES(LINES)) u0 (
        .clk(clk), .rst(rst), .flush_n(flush_n), .stop_clk(stop_clk),
        .init_req(init_req), .probe_rdy(probe_rdy), .ibound(ibound),
        .hi_pri_pend(hi_pri_pend), .wb_gnt(wb_gnt), .fill_en(fill_en),
        .fill_sel(fill_sel), .fill_idx(fill_idx), .fill_mod(fill_mod),
        .rd_sel(rd_sel), .rd_idx(rd_idx), .wb_req(wb_req), .wb_idx(wb_idx),
        .fack(fack), .busy(busy), .float_test(float_test),
        .rd_valid(rd_valid), .rd_mod(rd_mod)
    );

    // grant responder: withhold the grant gnt_delay cycles, log granted index
    always @(negedge clk) begin
        if (wb_req) begin
            if (gcnt == gnt_delay) begin
                wb_gnt <= 1'b1;
                if (nlog < 64) glog[nlog] = int'(wb_idx);
                nlog = nlog + 1;
                gcnt = 0;
            end else begin
                wb_gnt <= 1'b0;
                gcnt = gcnt + 1;
            end
        end else begin
            wb_gnt <= 1'b0;
            gcnt = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst = 1'b1;
        flush_n = pin;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic fill_line(input logic sel, input int idx, input logic md);
        @(negedge clk);
        fill_en = 1'b1; fill_sel = sel; fill_idx = IW'(idx); fill_mod = md;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic read_line(input logic sel, input int idx, output logic v, output logic m);
        rd_sel = sel; rd_idx = IW'(idx);
        #0.5;
        v = rd_valid; m = rd_mod;
    endtask

    task automatic count_valid(output int n);
        logic v, m;
        n = 0;
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < LINES; i++) begin
                read_line(s[0], i, v, m);
                if (v) n++;
            end
    endtask

    // pulse the pin one cycle at the current falling edge; record counts
    task automatic run_pass(input int maxk, input int repulse_at,
                            output int k_busy, output int k_fack, output int k_fack2,
                            output int k_fall, output int nfack);
        logic pb;
        k_busy = -1; k_fack = -1; k_fack2 = -1; k_fall = -1; nfack = 0; pb = 1'b0;
        flush_n = 1'b0;
        for (int k = 1; k <= maxk; k++) begin
            @(negedge clk);
            if (busy && k_busy < 0) k_busy = k;
            if (fack) begin
                nfack++;
                if (k_fack < 0) k_fack = k; else if (k_fack2 < 0) k_fack2 = k;
            end
            if (pb && !busy && k_fall < 0) k_fall = k;
            pb = busy;
            flush_n = (k == repulse_at) ? 1'b0 : 1'b1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end

    initial begin
        int kb, kf, kf2, kl, nf, nv, expf, npop;
        logic v, m;
        bit ok;

        do_reset(1'b1);
        // R10: reset state
        count_valid(nv);
        chk(nv == 0, "R10 reset lines invalid", nv, 0);
        chk(!busy && !fack && !wb_req, "R8 idle after reset", busy, 0);
        chk(float_test == 1'b0, "R7 no float with pin high", float_test, 0);

        // R10: fill and lookup encodings
        fill_line(1'b0, 3, 1'b1);
        fill_line(1'b0, 5, 1'b0);
        fill_line(1'b1, 2, 1'b1);
        read_line(1'b0, 3, v, m); chk(v && m, "R10 data modified", {v, m}, 3);
        read_line(1'b0, 5, v, m); chk(v && !m, "R10 data clean", {v, m}, 2);
        read_line(1'b0, 4, v, m); chk(!v && !m, "R10 data empty", {v, m}, 0);
        read_line(1'b1, 2, v, m); chk(v && !m, "R10 instr never modified", {v, m}, 2);

        // table of fill patterns and grant delays
        for (int t = 0; t < NVEC; t++) begin
            for (int i = 0; i < LINES; i++) fill_line(1'b0, i, V_MASK[t][i]);
            for (int i = 0; i < LINES; i++) fill_line(1'b1, i, 1'b0);
            gnt_delay = V_DLY[t];
            nlog = 0;
            @(negedge clk);
            run_pass(60, -1, kb, kf, kf2, kl, nf);
            npop = $countones(V_MASK[t]);
            expf = 4 + 2 * LINES + npop * (1 + V_DLY[t]);
            chk(kb == 4, $sformatf("R1 busy latency vec%0d", t), kb, 4);
            chk(kf == expf, $sformatf("R5 fack timing vec%0d", t), kf, expf);
            chk(nf == 1, $sformatf("R5 one fack vec%0d", t), nf, 1);
            chk(kl == expf + 1, $sformatf("R8 busy end vec%0d", t), kl, expf + 1);
            chk(nlog == npop, $sformatf("R11 writeback count vec%0d", t), nlog, npop);
            ok = 1'b1;
            begin
                int j;
                j = 0;
                for (int i = 0; i < LINES; i++)
                    if (V_MASK[t][i]) begin
                        if (j >= nlog || glog[j] != i) ok = 1'b0;
                        j++;
                    end
            end
            chk(ok, $sformatf("R3 writeback order vec%0d", t), nlog, npop);
            count_valid(nv);
            chk(nv == 0, $sformatf("R4 all invalid vec%0d", t), nv, 0);
        end

        // R9: edge during a pass gives a second full pass
        gnt_delay = 0;
        @(negedge clk);
        run_pass(60, 8, kb, kf, kf2, kl, nf);
        chk(nf == 2, "R9 two acks", nf, 2);
        chk(kf2 == 38, "R9 second ack timing", kf2, 38);

        // R2: boundary and priority gating
        @(negedge clk);
        ibound = 1'b0;
        flush_n = 1'b0;
        @(negedge clk); flush_n = 1'b1;
        ok = 1'b1;
        repeat (12) begin @(negedge clk); if (busy) ok = 1'b0; end
        chk(ok, "R2 waits for boundary", busy, 0);
        ibound = 1'b1; hi_pri_pend = 1'b1;
        ok = 1'b1;
        repeat (6) begin @(negedge clk); if (busy) ok = 1'b0; end
        chk(ok, "R2 waits for higher priority", busy, 0);
        hi_pri_pend = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R2 starts after priority clears", busy, 1);
        repeat (30) @(negedge clk);
        chk(!busy, "R2 pass completes", busy, 0);

        // R6: gated edges ignored, one per gating input
        for (int g = 0; g < 3; g++) begin
            @(negedge clk);
            stop_clk = (g == 0); init_req = (g == 1); probe_rdy = (g == 2);
            @(negedge clk); flush_n = 1'b0;
            @(negedge clk); flush_n = 1'b1;
            repeat (6) @(negedge clk);
            stop_clk = 1'b0; init_req = 1'b0; probe_rdy = 1'b0;
            ok = 1'b1;
            repeat (10) begin @(negedge clk); if (busy) ok = 1'b0; end
            chk(ok, $sformatf("R6 gated edge ignored g%0d", g), busy, 0);
        end
        // R6: level held low across the end of gating
        @(negedge clk); stop_clk = 1'b1;
        @(negedge clk); flush_n = 1'b0;
        repeat (6) @(negedge clk);
        stop_clk = 1'b0;
        ok = 1'b1;
        repeat (10) begin @(negedge clk); if (busy) ok = 1'b0; end
        chk(ok, "R6 held low level ignored", busy, 0);
        flush_n = 1'b1;
        repeat (4) @(negedge clk);

        // R7: pin low at reset release
        do_reset(1'b0);
        chk(float_test == 1'b1, "R7 float raised", float_test, 1);
        ok = 1'b1;
        repeat (20) begin @(negedge clk); if (busy) ok = 1'b0; end
        chk(ok, "R7 no flush on float", busy, 0);
        flush_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(float_test == 1'b1, "R7 float held", float_test, 1);
        do_reset(1'b1);
        chk(float_test == 1'b0, "R7 float cleared by reset", float_test, 0);

        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end

endmodule